// File: doc/BRIEF.md
# Programmable Counter Timebase Controller

This block is a free-running up-counter whose increment rate is chosen by a 3-bit source field in an 8-bit mode register. The counter can advance on every system clock, on one of two fixed prescaler outputs, on a pulse from a neighbouring timer, on synchronized falling edges of an external count pin, or on every eighth rising edge of a synchronized external clock. Each time the counter wraps from all ones to zero it sets a sticky overflow flag. Software clears that flag with a dedicated strobe. An interrupt request is raised while the flag is set and its enable bit is on.

The mode register also carries an idle-suspend control, which freezes counting while the processor reports idle, and two watchdog bits. The watchdog-enable bit is set out of reset. While it is set, the register accepts only one kind of write: a write that clears that bit, and only when the lock bit is clear. Once the lock bit is set together with the enable, the enable stays on until the next reset. The watchdog-enable state is exported so that a separate watchdog compare stage can use it.

Top module: `cnt_timebase`

## Requirements
- R1: After reset, mode_q reads 0x40, count_q is 0, ovf_flag and irq are 0, and wdog_en is 1. The mode bit layout is: bit 7 idle-suspend, bit 6 watchdog enable, bit 5 watchdog lock, bit 4 unused, bits 3:1 source select, bit 0 overflow interrupt enable.
- R2: While bit 6 is 1, a mode write takes effect only if its bit 6 is 0 and the stored lock bit (bit 5) is 0. Such a write clears bit 6 and leaves every other bit unchanged. Any other write in this state is ignored.
- R3: While bits 6 and 5 are both 1, no mode write changes the register until reset.
- R4: While bit 6 is 0, a mode write loads all bits except bit 4, which always reads 0.
- R5: Select 000 advances the counter once per 12 system clocks, and select 001 once per 4 system clocks.
- R6: Select 100 advances the counter on every system clock. Selects 110 and 111 hold the counter value.
- R7: Select 010 advances the counter once for each cycle in which t0_ovf is 1.
- R8: Select 011 advances the counter once per falling edge of ext_cnt_in, after a two-flop synchronizer. The input toggles no faster than once per 4 clocks, and each edge is counted by the third clock edge after the change.
- R9: Select 101 advances the counter once per 8 synchronized rising edges of ext_clk_in.
- R10: When bit 7 is 1 and cpu_idle is 1, the counter holds. When bit 7 is 0, cpu_idle has no effect.
- R11: A counter advance from 0xFFFF to 0x0000 sets ovf_flag. The flag stays set until an ovf_clr pulse, and a wrap in the same cycle as ovf_clr wins.
- R12: irq is 1 exactly when ovf_flag is 1 and mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cpu_idle | input | 1 | Processor idle indication |
| t0_ovf | input | 1 | One-cycle overflow pulse from timer 0 |
| ext_cnt_in | input | 1 | Asynchronous external count input (falling edges counted) |
| ext_clk_in | input | 1 | Asynchronous external clock |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | 16 | Current counter value |
| mode_q | output | 8 | Current mode register value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Watchdog-enable state |

## Verification
A corrupted prescaler phase or divider count shows up as a wrong counter delta over a window that is a whole multiple of the divisor. It is therefore visible within one window of 12 clocks or less for the internal prescalers and 8 external edges for the external divider. A wrong protection state shows up at mode_q on the clock edge after the rejected or accepted write. A lost or spurious overflow shows at ovf_flag and irq on the first edge past the wrap, and persists because the flag is sticky. Synchronizer or edge-detector faults change the count of external edges, and that count is compared after a flush of a few clocks.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    typedef enum logic [2:0] {
        SRC_DIV_SLOW = 3'b000,
        SRC_DIV_FAST = 3'b001,
        SRC_T0_OVF   = 3'b010,
        SRC_EXT_FALL = 3'b011,
        SRC_SYSCLK   = 3'b100,
        SRC_EXT_DIV  = 3'b101,
        SRC_RSV6     = 3'b110,
        SRC_RSV7     = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic     idle_sus;
        logic     wd_en;
        logic     wd_lock;
        logic     unused;
        src_sel_e sel;
        logic     ovf_ie;
    } mode_t;

    localparam logic [7:0] MODE_RST = 8'h40;

endpackage

// File: rtl/ctb_sync.sv
module ctb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sh <= {STAGES{RST_VAL}};
        else        st_q    <= st_d;
    end

    assign dout = st_q.sh[STAGES-1];

endmodule

// File: rtl/ctb_mode_reg.sv
module ctb_mode_reg
    import ctb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output mode_t      mode_q
);
    mode_t mode_d;
    mode_t wr_val;

    always_comb begin
        wr_val        = mode_t'(wdata);
        wr_val.unused = 1'b0;
        mode_d        = mode_q;
        if (wr) begin
            if (!mode_q.wd_en) begin
                mode_d = wr_val;
            end else if (!wr_val.wd_en && !mode_q.wd_lock) begin
                mode_d.wd_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_t'(MODE_RST);
        else        mode_q <= mode_d;
    end

    // R2: with the watchdog on, a write never touches bits other than bit 6
    a_r2_wd_write_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.wd_en && wr) |=> ((mode_q & 8'hBF) == ($past(mode_q) & 8'hBF)));

    // R3: locked watchdog enable never drops
    a_r3_lock_keeps_wd: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.wd_en && mode_q.wd_lock) |=> (mode_q.wd_en && mode_q.wd_lock));

endmodule

// File: rtl/ctb_src.sv
module ctb_src
    import ctb_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e sel,
    input  logic     t0_ovf,
    input  logic     ext_cnt_in,
    input  logic     ext_clk_in,
    output logic     tick
);
    localparam int SLOW_W = $clog2(DIV_SLOW);
    localparam int FAST_W = $clog2(DIV_FAST);
    localparam int EDIV_W = $clog2(EXT_DIV);
    localparam logic [SLOW_W-1:0] SLOW_MAX = SLOW_W'(DIV_SLOW - 1);
    localparam logic [FAST_W-1:0] FAST_MAX = FAST_W'(DIV_FAST - 1);
    localparam logic [EDIV_W-1:0] EDIV_MAX = EDIV_W'(EXT_DIV - 1);

    typedef struct packed {
        logic [SLOW_W-1:0] slow;
        logic [FAST_W-1:0] fast;
        logic              fall_last;
        logic              eclk_last;
        logic [EDIV_W-1:0] ediv;
    } st_t;

    st_t  st_d, st_q;
    logic cnt_s, eclk_s;
    logic slow_tick, fast_tick, fall, eclk_rise, ediv_tick;

    ctb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cnt (
        .clk(clk), .rst_n(rst_n), .din(ext_cnt_in), .dout(cnt_s)
    );

    ctb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_eclk (
        .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .dout(eclk_s)
    );

    always_comb begin
        slow_tick = (st_q.slow == SLOW_MAX);
        fast_tick = (st_q.fast == FAST_MAX);
        fall      = st_q.fall_last & ~cnt_s;
        eclk_rise = eclk_s & ~st_q.eclk_last;
        ediv_tick = eclk_rise && (st_q.ediv == EDIV_MAX);

        st_d           = st_q;
        st_d.slow      = slow_tick ? '0 : st_q.slow + SLOW_W'(1);
        st_d.fast      = fast_tick ? '0 : st_q.fast + FAST_W'(1);
        st_d.fall_last = cnt_s;
        st_d.eclk_last = eclk_s;
        if (eclk_rise) begin
            st_d.ediv = (st_q.ediv == EDIV_MAX) ? '0 : st_q.ediv + EDIV_W'(1);
        end

        unique case (sel)
            SRC_DIV_SLOW: tick = slow_tick;
            SRC_DIV_FAST: tick = fast_tick;
            SRC_T0_OVF:   tick = t0_ovf;
            SRC_EXT_FALL: tick = fall;
            SRC_SYSCLK:   tick = 1'b1;
            SRC_EXT_DIV:  tick = ediv_tick;
            default:      tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slow      <= '0;
            st_q.fast      <= '0;
            st_q.fall_last <= 1'b1;
            st_q.eclk_last <= 1'b0;
            st_q.ediv      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: reserved selects never produce a count enable
    a_r6_reserved_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SRC_RSV6) || (sel == SRC_RSV7)) |-> !tick);

    // R5: the slow prescaler wraps back to zero after its terminal value
    a_r5_slow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slow == SLOW_MAX) |=> (st_q.slow == '0));

endmodule

// File: rtl/ctb_counter.sv
module ctb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } st_t;

    st_t  st_d, st_q;
    logic wrap;

    always_comb begin
        wrap = en && (st_q.cnt == '1);
        st_d = st_q;
        if (en)   st_d.cnt = st_q.cnt + CNT_W'(1);
        if (clr)  st_d.ovf = 1'b0;
        if (wrap) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    // R11: advancing past all ones lands on zero with the flag set
    a_r11_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt == '1)) |=> (ovf && (cnt == '0)));

    // R11: the flag stays set until a clear strobe
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R6: no enable, no change in value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

// File: rtl/cnt_timebase.sv
module cnt_timebase
    import ctb_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [7:0]       mode_wdata,
    input  logic             cpu_idle,
    input  logic             t0_ovf,
    input  logic             ext_cnt_in,
    input  logic             ext_clk_in,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count_q,
    output logic [7:0]       mode_q,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wdog_en
);
    mode_t mode_s;
    logic  tick;
    logic  count_en;

    ctb_mode_reg i_mode (
        .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata), .mode_q(mode_s)
    );

    ctb_src #(
        .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
        .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
    ) i_src (
        .clk(clk), .rst_n(rst_n), .sel(mode_s.sel), .t0_ovf(t0_ovf),
        .ext_cnt_in(ext_cnt_in), .ext_clk_in(ext_clk_in), .tick(tick)
    );

    always_comb begin
        count_en = tick && !(mode_s.idle_sus && cpu_idle);
    end

    ctb_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .en(count_en), .clr(ovf_clr),
        .cnt(count_q), .ovf(ovf_flag)
    );

    assign mode_q  = mode_s;
    assign irq     = ovf_flag && mode_s.ovf_ie;
    assign wdog_en = mode_s.wd_en;

    // R10: idle with suspend enabled freezes the count
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s.idle_sus && cpu_idle) |=> $stable(count_q));

endmodule

// File: tb/test_cnt_timebase.sv
`timescale 1ns/1ps
module test_cnt_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = 8'h00;
    logic        cpu_idle = 1'b0;
    logic        t0_ovf = 1'b0;
    logic        ext_cnt_in = 1'b1;
    logic        ext_clk_in = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count_q;
    logic [7:0]  mode_q;
    logic        ovf_flag, irq, wdog_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cnt_timebase i_cnt_timebase (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cpu_idle(cpu_idle), .t0_ovf(t0_ovf), .ext_cnt_in(ext_cnt_in),
        .ext_clk_in(ext_clk_in), .ovf_clr(ovf_clr), .count_q(count_q),
        .mode_q(mode_q), .ovf_flag(ovf_flag), .irq(irq), .wdog_en(wdog_en)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic        ictl;
        logic        idle;
        logic [10:0] cyc;
        logic [15:0] exp_delta;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 1'b0, 11'd120, 16'd10},
        '{3'd1, 1'b0, 1'b0, 11'd40,  16'd10},
        '{3'd4, 1'b0, 1'b0, 11'd37,  16'd37},
        '{3'd6, 1'b0, 1'b0, 11'd50,  16'd0},
        '{3'd7, 1'b0, 1'b0, 11'd50,  16'd0},
        '{3'd4, 1'b1, 1'b1, 11'd30,  16'd0},
        '{3'd4, 1'b0, 1'b1, 11'd30,  16'd30},
        '{3'd4, 1'b1, 1'b0, 11'd30,  16'd30},
        '{3'd0, 1'b1, 1'b1, 11'd120, 16'd0}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_wdata = v;
        mode_wr    = 1'b1;
        step(1);
        mode_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 mode", {8'h0, mode_q}, 16'h0040);
        chk("R1 count", count_q, 16'h0000);
        chk("R1 flag/irq/wdog", {13'h0, ovf_flag, irq, wdog_en}, 16'h0001);

        // R2: write with bit 6 set while watchdog on is ignored
        wr_mode(8'hFF);
        chk("R2 ignored write", {8'h0, mode_q}, 16'h0040);
        // R2: clearing write changes only bit 6
        wr_mode(8'hBF);
        chk("R2 clear only wd", {8'h0, mode_q}, 16'h0000);
        chk("R2 wdog_en low", {15'h0, wdog_en}, 16'h0000);
        // R4: full load, bit 4 forced to 0
        wr_mode(8'hFF);
        chk("R4 load bit4 zero", {8'h0, mode_q}, 16'h00EF);
        // R3: locked
        wr_mode(8'h0E);
        chk("R3 locked clear", {8'h0, mode_q}, 16'h00EF);
        wr_mode(8'h00);
        chk("R3 locked zero", {8'h0, mode_q}, 16'h00EF);
        do_reset();
        chk("R3 reset unlocks", {8'h0, mode_q}, 16'h0040);

        wr_mode(8'h00);
        chk("R2 wd cleared", {8'h0, mode_q}, 16'h0000);

        // R5 R6 R10 table
        for (int i = 0; i < NV; i++) begin
            cpu_idle = VEC[i].idle;
            wr_mode({VEC[i].ictl, 3'b000, VEC[i].sel, 1'b0});
            c0 = count_q;
            step(int'(VEC[i].cyc));
            if (VEC[i].ictl || VEC[i].idle)
                chk($sformatf("R10 vector %0d", i), count_q - c0, VEC[i].exp_delta);
            else if (VEC[i].sel >= 3'd4)
                chk($sformatf("R6 vector %0d", i), count_q - c0, VEC[i].exp_delta);
            else
                chk($sformatf("R5 vector %0d", i), count_q - c0, VEC[i].exp_delta);
        end
        cpu_idle = 1'b0;

        // R7: timer-0 pulses
        wr_mode(8'h04);
        c0 = count_q;
        for (int k = 0; k < 7; k++) begin
            t0_ovf = 1'b1; step(1);
            t0_ovf = 1'b0; step(2);
        end
        chk("R7 t0 pulses", count_q - c0, 16'd7);

        // R8: falling edges of external count input
        wr_mode(8'h06);
        c0 = count_q;
        for (int k = 0; k < 5; k++) begin
            ext_cnt_in = 1'b0; step(4);
            ext_cnt_in = 1'b1; step(4);
        end
        step(4);
        chk("R8 falling edges", count_q - c0, 16'd5);

        // R9: external clock divided by 8
        wr_mode(8'h0A);
        c0 = count_q;
        for (int k = 0; k < 40; k++) begin
            ext_clk_in = 1'b1; step(2);
            ext_clk_in = 1'b0; step(2);
        end
        step(4);
        chk("R9 ext div8", count_q - c0, 16'd5);

        // R11 R12: overflow
        wr_mode(8'h0C);
        c0 = count_q;
        wr_mode(8'h09);
        chk("R6 hold before run", count_q, c0);
        step(65535 - int'(c0));
        chk("R11 at max", count_q, 16'hFFFF);
        chk("R11 no flag yet", {15'h0, ovf_flag}, 16'h0000);
        step(1);
        chk("R11 wrapped", count_q, 16'h0000);
        chk("R11 flag set", {15'h0, ovf_flag}, 16'h0001);
        chk("R12 irq on", {15'h0, irq}, 16'h0001);
        wr_mode(8'h0C);
        chk("R11 flag sticky", {15'h0, ovf_flag}, 16'h0001);
        chk("R12 irq masked", {15'h0, irq}, 16'h0000);
        wr_mode(8'h0D);
        chk("R12 irq unmasked", {15'h0, irq}, 16'h0001);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        chk("R11 flag cleared", {15'h0, ovf_flag}, 16'h0000);
        chk("R12 irq after clear", {15'h0, irq}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule